// File: doc/BRIEF.md
# Configuration Space Access Port

This block gives a host processor indirect access to bus configuration space through a pair of memory-mapped registers. The host first writes a selector register that holds an enable flag together with the bus, device, function and dword index of the target configuration register. It then reads or writes a data window. Each window access becomes exactly one configuration request on a valid/ready request channel, and the block waits for a matching response.

Two further registers sit beside the pair. The control register holds the I/O-space, memory-space and bus-master enable bits, and each bit drives an output pin. The I/O-size register is a small field in which code 0 selects a 1 MB I/O window.

For narrow writes the host places the value in the low bits of its write data and addresses the window at its base plus the low two bits of the configuration register number. The block derives the byte enables from that offset and moves the data onto the matching byte lanes. Reads always fetch a whole dword. While a request is in flight the host bus is held off with ready low.

Top module: `cfgp_access_port`

## Requirements
- R1: A write to byte offset 0x28 loads the selector: enable from bit 31, bus from bits 23:16, device from bits 15:11, function from bits 10:8 and dword index from bits 7:2. A read of 0x28 returns those fields in the same positions, with bits 30:24 and 1:0 read as zero.
- R2: Every downstream request carries the bus, device, function and dword index currently held in the selector.
- R3: A word access (host_size 2 or 3) to the window at 0x2C–0x2F transfers a full dword. A write uses byte enables 1111 and passes host_wdata unchanged.
- R4: A halfword write (host_size 1) takes its value from host_wdata[15:0]. When host_addr[1] is 0 it uses byte enables 0011 with the data in bits 15:0. When host_addr[1] is 1 it uses 1100 with the data in bits 31:16. Lanes that are not enabled carry zero.
- R5: A byte write (host_size 0) takes its value from host_wdata[7:0]. It uses the one-hot byte enable 1 << host_addr[1:0] and places the data at bit 8*host_addr[1:0]. All other lanes carry zero.
- R6: A window read of any size issues a request with byte enables 1111 and returns the full response dword on host_rdata.
- R7: While the selector enable is 0, a window read completes at once with 0xFFFFFFFF and a window write is dropped. Neither issues a request.
- R8: With the selector enabled, a window access keeps host_ready low until the response has been taken. The request fields stay stable while cfg_req_ready is low. An access with S stall cycles at the target and a response latency of L cycles shows host_ready low on 4+S+L consecutive cycles.
- R9: Offset 0x08 is the control register. Bit 0 drives ctl_io_en, bit 1 drives ctl_mem_en and bit 2 drives ctl_master_en. Reads return those three bits, with the upper bits read as zero.
- R10: Offset 0x00 holds the I/O-size field (IOSZ_W bits, value 0 meaning 1 MB). It drives io_size and reads back zero-extended.
- R11: After reset all registers are zero, no request is pending and host_ready is high.
- R12: Writes to unmapped offsets change no register, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_valid | input | 1 | Host access request, held until host_ready |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | ADDR_W | Byte offset within the block |
| host_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_wdata | input | 32 | Write value, low-aligned for narrow writes |
| host_ready | output | 1 | Access completes on a cycle with valid and ready |
| host_rdata | output | 32 | Read data, valid when host_ready is high |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Target accepts the request |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_dev | output | 5 | Target device number |
| cfg_req_fn | output | 3 | Target function number |
| cfg_req_idx | output | 6 | Dword register index |
| cfg_req_be | output | 4 | Byte enables |
| cfg_req_wdata | output | 32 | Lane-aligned write data |
| cfg_rsp_valid | input | 1 | Response for the accepted request |
| cfg_rsp_rdata | input | 32 | Response dword |
| ctl_io_en | output | 1 | I/O-space enable |
| ctl_mem_en | output | 1 | Memory-space enable |
| ctl_master_en | output | 1 | Bus-master enable |
| io_size | output | IOSZ_W | I/O window size code |

## Verification
The window is exercised with word, halfword and byte writes at every legal offset, and each is followed by a full read that shows whether only the intended lanes of the modelled dword changed. This separates wrong byte enables from wrong data placement. Accesses with the selector disabled are followed by an enabled read, which shows whether a dropped write really left the target untouched. A run with target stall and response latency added, counted against zero-delay runs, shows whether the host is held for exactly the in-flight window. Selector values with all bits set detect fields that leak into the reserved bits.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int BUS_W   = 8;
  localparam int DEV_W   = 5;
  localparam int FN_W    = 3;
  localparam int IDX_W   = 6;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef struct packed {
    logic             en;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [IDX_W-1:0] idx;
  } sel_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cfgp_rst_sync.sv
`timescale 1ns/1ps
module cfgp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cfgp_regs.sv
`timescale 1ns/1ps
module cfgp_regs
  import cfgp_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              IOSZ_W   = 4,
  parameter logic [ADDR_W-1:0] OFF_SEL  = 8'h28,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_IOSZ = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-3:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output sel_t              sel_o,
  output logic [2:0]        ctl_o,
  output logic [IOSZ_W-1:0] iosz_o,
  output logic [DATA_W-1:0] rd_o
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] WA_SEL  = OFF_SEL[ADDR_W-1:2];
  localparam logic [WA_W-1:0] WA_CTRL = OFF_CTRL[ADDR_W-1:2];
  localparam logic [WA_W-1:0] WA_IOSZ = OFF_IOSZ[ADDR_W-1:2];

  sel_t              sel_q, sel_d;
  logic [2:0]        ctl_q, ctl_d;
  logic [IOSZ_W-1:0] iosz_q, iosz_d;
  logic              sel_ld, ctl_ld, iosz_ld;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[30:24], wdata[1:0]};

  // Load enables and next values
  always_comb begin
    sel_ld  = wr_en && (waddr == WA_SEL);
    ctl_ld  = wr_en && (waddr == WA_CTRL);
    iosz_ld = wr_en && (waddr == WA_IOSZ);
    sel_d.en  = wdata[31];
    sel_d.bus = wdata[23:16];
    sel_d.dev = wdata[15:11];
    sel_d.fn  = wdata[10:8];
    sel_d.idx = wdata[7:2];
    ctl_d   = wdata[2:0];
    iosz_d  = wdata[IOSZ_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_ld) sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ld) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       iosz_q <= '0;
    else if (iosz_ld) iosz_q <= iosz_d;
  end

  // Readback
  always_comb begin
    rd_o = '0;
    if (waddr == WA_SEL)
      rd_o = {sel_q.en, 7'b0, sel_q.bus, sel_q.dev, sel_q.fn, sel_q.idx, 2'b00};
    else if (waddr == WA_CTRL)
      rd_o = {{(DATA_W-3){1'b0}}, ctl_q};
    else if (waddr == WA_IOSZ)
      rd_o = {{(DATA_W-IOSZ_W){1'b0}}, iosz_q};
  end

  assign sel_o  = sel_q;
  assign ctl_o  = ctl_q;
  assign iosz_o = iosz_q;
endmodule

// File: rtl/cfgp_lane.sv
`timescale 1ns/1ps
module cfgp_lane
  import cfgp_pkg::*;
(
  input  logic              we_i,
  input  logic [1:0]        off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] shifted;

  always_comb begin
    be_o    = '1;
    shifted = wdata_i;
    if (we_i) begin
      if (size_i == SZ_BYTE) begin
        be_o    = LANES'(1) << off_i;
        shifted = wdata_i << {off_i, 3'b000};
      end else if (size_i == SZ_HALF) begin
        be_o    = off_i[1] ? 4'b1100 : 4'b0011;
        shifted = off_i[1] ? (wdata_i << 16) : wdata_i;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign data_o[8*i +: 8] = be_o[i] ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/cfgp_seq.sv
`timescale 1ns/1ps
module cfgp_seq
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [LANES-1:0]  req_be_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic              host_ready_o,
  output logic [DATA_W-1:0] rdata_o
);
  seq_state_e        st_q, st_d;
  logic              cap_ld, rsp_ld;
  logic              wr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    st_d         = st_q;
    cap_ld       = 1'b0;
    rsp_ld       = 1'b0;
    host_ready_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        host_ready_o = !start_i;
        if (start_i) begin
          cap_ld = 1'b1;
          st_d   = SQ_ISSUE;
        end
      end
      SQ_ISSUE: if (req_ready_i) st_d = SQ_WAIT;
      SQ_WAIT: if (rsp_valid_i) begin
        rsp_ld = 1'b1;
        st_d   = SQ_DONE;
      end
      SQ_DONE: begin
        host_ready_o = 1'b1;
        st_d         = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      be_q <= '0;
      wd_q <= '0;
    end else if (cap_ld) begin
      wr_q <= we_i;
      be_q <= be_i;
      wd_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rsp_ld) rd_q <= rsp_rdata_i;
  end

  assign req_valid_o = (st_q == SQ_ISSUE);
  assign req_write_o = wr_q;
  assign req_be_o    = be_q;
  assign req_wdata_o = wd_q;
  assign rdata_o     = rd_q;
endmodule

// File: rtl/cfgp_access_port.sv
`timescale 1ns/1ps
module cfgp_access_port
  import cfgp_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                IOSZ_W   = 4,
  parameter logic [ADDR_W-1:0] OFF_IOSZ = 8'h00,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_SEL  = 8'h28,
  parameter logic [ADDR_W-1:0] OFF_DATA = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic              host_ready,
  output logic [31:0]       host_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_req_write,
  output logic [7:0]        cfg_req_bus,
  output logic [4:0]        cfg_req_dev,
  output logic [2:0]        cfg_req_fn,
  output logic [5:0]        cfg_req_idx,
  output logic [3:0]        cfg_req_be,
  output logic [31:0]       cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [31:0]       cfg_rsp_rdata,
  output logic              ctl_io_en,
  output logic              ctl_mem_en,
  output logic              ctl_master_en,
  output logic [IOSZ_W-1:0] io_size
);
  localparam logic [ADDR_W-3:0] WA_DATA = OFF_DATA[ADDR_W-1:2];

  logic              rst_n_i;
  sel_t              sel;
  logic              sel_en;
  logic [2:0]        ctl;
  logic [DATA_W-1:0] reg_rd;
  logic              win_hit;
  logic              win_start;
  logic              reg_wr;
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] lane_data;
  logic              seq_ready;
  logic [DATA_W-1:0] seq_rdata;

  cfgp_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign win_hit   = (host_addr[ADDR_W-1:2] == WA_DATA);
  assign sel_en    = sel.en;
  assign win_start = host_valid && win_hit && sel_en;
  assign reg_wr    = host_valid && host_ready && host_we && !win_hit;

  cfgp_regs #(
    .ADDR_W   (ADDR_W),
    .IOSZ_W   (IOSZ_W),
    .OFF_SEL  (OFF_SEL),
    .OFF_CTRL (OFF_CTRL),
    .OFF_IOSZ (OFF_IOSZ)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_en  (reg_wr),
    .waddr  (host_addr[ADDR_W-1:2]),
    .wdata  (host_wdata),
    .sel_o  (sel),
    .ctl_o  (ctl),
    .iosz_o (io_size),
    .rd_o   (reg_rd)
  );

  cfgp_lane lane_i (
    .we_i    (host_we),
    .off_i   (host_addr[1:0]),
    .size_i  (host_size),
    .wdata_i (host_wdata),
    .be_o    (lane_be),
    .data_o  (lane_data)
  );

  cfgp_seq seq_i (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .start_i      (win_start),
    .we_i         (host_we),
    .be_i         (lane_be),
    .wdata_i      (lane_data),
    .req_valid_o  (cfg_req_valid),
    .req_ready_i  (cfg_req_ready),
    .req_write_o  (cfg_req_write),
    .req_be_o     (cfg_req_be),
    .req_wdata_o  (cfg_req_wdata),
    .rsp_valid_i  (cfg_rsp_valid),
    .rsp_rdata_i  (cfg_rsp_rdata),
    .host_ready_o (seq_ready),
    .rdata_o      (seq_rdata)
  );

  assign host_ready = seq_ready;

  always_comb begin
    if (!win_hit)    host_rdata = reg_rd;
    else if (sel_en) host_rdata = seq_rdata;
    else             host_rdata = '1;
  end

  assign cfg_req_bus   = sel.bus;
  assign cfg_req_dev   = sel.dev;
  assign cfg_req_fn    = sel.fn;
  assign cfg_req_idx   = sel.idx;
  assign ctl_io_en     = ctl[0];
  assign ctl_mem_en    = ctl[1];
  assign ctl_master_en = ctl[2];
endmodule

// File: rtl/cfgp_access_port_chk.sv
`timescale 1ns/1ps
module cfgp_access_port_chk #(
  parameter int IOSZ_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_we,
  input logic              host_ready,
  input logic              cfg_req_valid,
  input logic              cfg_req_ready,
  input logic              cfg_req_write,
  input logic [3:0]        cfg_req_be,
  input logic [31:0]       cfg_req_wdata,
  input logic              sel_en,
  input logic              ctl_io_en,
  input logic              ctl_mem_en,
  input logic              ctl_master_en,
  input logic [IOSZ_W-1:0] io_size
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_be)
      && $stable(cfg_req_wdata) && $stable(cfg_req_write));

  // R8
  host_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> !host_ready);

  // R6
  rd_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_write |-> cfg_req_be == 4'hF);

  // R4
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> ($countones(cfg_req_be) == 1) || cfg_req_be == 4'h3
      || cfg_req_be == 4'hC || cfg_req_be == 4'hF);

  // R7
  dis_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_en |=> !cfg_req_valid);

  // R9
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && host_we) |=> $stable({ctl_io_en, ctl_mem_en, ctl_master_en, io_size}));
endmodule

bind cfgp_access_port cfgp_access_port_chk #(.IOSZ_W(IOSZ_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_valid    (host_valid),
  .host_we       (host_we),
  .host_ready    (host_ready),
  .cfg_req_valid (cfg_req_valid),
  .cfg_req_ready (cfg_req_ready),
  .cfg_req_write (cfg_req_write),
  .cfg_req_be    (cfg_req_be),
  .cfg_req_wdata (cfg_req_wdata),
  .sel_en        (sel_en),
  .ctl_io_en     (ctl_io_en),
  .ctl_mem_en    (ctl_mem_en),
  .ctl_master_en (ctl_master_en),
  .io_size       (io_size)
);

// File: tb/cfgp_access_port_tb_top.sv
`timescale 1ns/1ps
module cfgp_access_port_tb_top;
  localparam logic [7:0] A_IOSZ = 8'h00;
  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_SEL  = 8'h28;
  localparam logic [7:0] A_WIN  = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic        cfg_req_valid, cfg_req_ready, cfg_req_write;
  logic [7:0]  cfg_req_bus;
  logic [4:0]  cfg_req_dev;
  logic [2:0]  cfg_req_fn;
  logic [5:0]  cfg_req_idx;
  logic [3:0]  cfg_req_be;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;
  logic        ctl_io_en, ctl_mem_en, ctl_master_en;
  logic [3:0]  io_size;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cfgp_access_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
    .host_size(host_size), .host_wdata(host_wdata),
    .host_ready(host_ready), .host_rdata(host_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_write(cfg_req_write), .cfg_req_bus(cfg_req_bus),
    .cfg_req_dev(cfg_req_dev), .cfg_req_fn(cfg_req_fn), .cfg_req_idx(cfg_req_idx),
    .cfg_req_be(cfg_req_be), .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata),
    .ctl_io_en(ctl_io_en), .ctl_mem_en(ctl_mem_en), .ctl_master_en(ctl_master_en),
    .io_size(io_size)
  );

  // Target model
  logic [31:0] mem [16];
  int          tgt_stall = 0;
  int          tgt_lat   = 0;
  int          wait_cnt  = 0;
  int          lat_cnt   = 0;
  bit          pend      = 1'b0;
  int          req_count = 0;
  logic [7:0]  last_bus;
  logic [4:0]  last_dev;
  logic [2:0]  last_fn;
  logic [5:0]  last_idx;
  logic [3:0]  last_be;
  logic [31:0] last_wdata;
  logic        last_write;

  assign cfg_req_ready = (wait_cnt >= tgt_stall);

  initial for (int i = 0; i < 16; i++) mem[i] = 32'h0;

  always @(posedge clk) begin
    cfg_rsp_valid <= 1'b0;
    if (cfg_req_valid && cfg_req_ready) begin
      wait_cnt   <= 0;
      pend       <= 1'b1;
      lat_cnt    <= 0;
      req_count  <= req_count + 1;
      last_bus   <= cfg_req_bus;
      last_dev   <= cfg_req_dev;
      last_fn    <= cfg_req_fn;
      last_idx   <= cfg_req_idx;
      last_be    <= cfg_req_be;
      last_wdata <= cfg_req_wdata;
      last_write <= cfg_req_write;
      if (cfg_req_write)
        for (int i = 0; i < 4; i++)
          if (cfg_req_be[i]) mem[cfg_req_idx[3:0]][8*i +: 8] <= cfg_req_wdata[8*i +: 8];
    end else if (cfg_req_valid) begin
      wait_cnt <= wait_cnt + 1;
    end
    if (pend) begin
      if (lat_cnt == tgt_lat) begin
        cfg_rsp_valid <= 1'b1;
        cfg_rsp_rdata <= mem[last_idx[3:0]];
        pend          <= 1'b0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_acc(input logic we, input logic [7:0] addr, input logic [1:0] size,
                          input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    host_valid = 1'b1; host_we = we; host_addr = addr; host_size = size; host_wdata = wd;
    waits = 0;
    #1;
    while (!host_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = host_rdata;
    @(posedge clk);
    #1;
    host_valid = 1'b0;
  endtask

  function automatic logic [31:0] sel_word(input bit en, input logic [7:0] b,
                                           input logic [4:0] d, input logic [2:0] f,
                                           input logic [5:0] x);
    return {en, 7'b0, b, d, f, x, 2'b00};
  endfunction

  task automatic t_reset();
    logic [31:0] rd; int w;
    chk("R11 host_ready", {31'b0, host_ready}, 32'd1);
    chk("R11 req_valid", {31'b0, cfg_req_valid}, 32'd0);
    chk("R11 ctl pins", {29'b0, ctl_master_en, ctl_mem_en, ctl_io_en}, 32'd0);
    chk("R11 io_size", {28'b0, io_size}, 32'd0);
    host_acc(1'b0, A_SEL, 2'd2, 32'h0, rd, w);
    chk("R11 selector read", rd, 32'h0);
  endtask

  task automatic t_selector();
    logic [31:0] rd; int w;
    host_acc(1'b1, A_SEL, 2'd2, 32'hFFFF_FFFF, rd, w);
    host_acc(1'b0, A_SEL, 2'd2, 32'h0, rd, w);
    chk("R1 all ones readback", rd, 32'h80FF_FFFC);
    host_acc(1'b1, A_SEL, 2'd2, 32'h00AB_5A3F, rd, w);
    host_acc(1'b0, A_SEL, 2'd2, 32'h0, rd, w);
    chk("R1 fields readback", rd, 32'h00AB_5A3C);
  endtask

  task automatic t_ctrl();
    logic [31:0] rd; int w;
    host_acc(1'b1, A_CTRL, 2'd2, 32'hFFFF_FFF5, rd, w);
    chk("R9 pins io+master", {29'b0, ctl_master_en, ctl_mem_en, ctl_io_en}, 32'd5);
    host_acc(1'b0, A_CTRL, 2'd2, 32'h0, rd, w);
    chk("R9 readback", rd, 32'd5);
    host_acc(1'b1, A_CTRL, 2'd2, 32'h0000_0002, rd, w);
    chk("R9 pins mem only", {29'b0, ctl_master_en, ctl_mem_en, ctl_io_en}, 32'd2);
  endtask

  task automatic t_iosize();
    logic [31:0] rd; int w;
    host_acc(1'b1, A_IOSZ, 2'd2, 32'hFFFF_FFFA, rd, w);
    chk("R10 io_size pin", {28'b0, io_size}, 32'hA);
    host_acc(1'b0, A_IOSZ, 2'd2, 32'h0, rd, w);
    chk("R10 readback", rd, 32'hA);
    host_acc(1'b1, A_IOSZ, 2'd2, 32'h0, rd, w);
    chk("R10 1MB code", {28'b0, io_size}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] rd; int w;
    host_acc(1'b1, 8'h10, 2'd2, 32'hDEAD_BEEF, rd, w);
    host_acc(1'b0, 8'h10, 2'd2, 32'h0, rd, w);
    chk("R12 unmapped read", rd, 32'h0);
    chk("R12 ctl unchanged", {29'b0, ctl_master_en, ctl_mem_en, ctl_io_en}, 32'd2);
    chk("R12 io_size unchanged", {28'b0, io_size}, 32'h0);
    host_acc(1'b0, A_SEL, 2'd2, 32'h0, rd, w);
    chk("R12 selector unchanged", rd, 32'h00AB_5A3C);
  endtask

  task automatic t_word();
    logic [31:0] rd; int w; int n0;
    host_acc(1'b1, A_SEL, 2'd2, sel_word(1'b1, 8'h12, 5'h07, 3'h3, 6'h05), rd, w);
    n0 = req_count;
    host_acc(1'b1, A_WIN, 2'd2, 32'h1122_3344, rd, w);
    chk("R3 one request", req_count - n0, 32'd1);
    chk("R3 be", {28'b0, last_be}, 32'hF);
    chk("R3 wdata", last_wdata, 32'h1122_3344);
    chk("R3 write flag", {31'b0, last_write}, 32'd1);
    chk("R2 fields", {last_bus, 3'b0, last_dev, 5'b0, last_fn, 2'b0, last_idx},
        {8'h12, 3'b0, 5'h07, 5'b0, 3'h3, 2'b0, 6'h05});
    host_acc(1'b0, A_WIN, 2'd2, 32'h0, rd, w);
    chk("R3 word read", rd, 32'h1122_3344);
    chk("R8 zero-delay waits", w, 32'd4);
  endtask

  task automatic t_half();
    logic [31:0] rd; int w;
    host_acc(1'b1, A_WIN + 8'd2, 2'd1, 32'hFFFF_BEEF, rd, w);
    chk("R4 upper be", {28'b0, last_be}, 32'hC);
    chk("R4 upper data", last_wdata, 32'hBEEF_0000);
    host_acc(1'b1, A_WIN, 2'd1, 32'hAAAA_1234, rd, w);
    chk("R4 lower be", {28'b0, last_be}, 32'h3);
    chk("R4 lower data", last_wdata, 32'h0000_1234);
    host_acc(1'b0, A_WIN + 8'd2, 2'd1, 32'h0, rd, w);
    chk("R6 half read full dword", rd, 32'hBEEF_1234);
    chk("R6 read be", {28'b0, last_be}, 32'hF);
  endtask

  task automatic t_byte();
    logic [31:0] rd; int w;
    host_acc(1'b1, A_WIN + 8'd1, 2'd0, 32'h0000_00A5, rd, w);
    chk("R5 lane1 be", {28'b0, last_be}, 32'h2);
    chk("R5 lane1 data", last_wdata, 32'h0000_A500);
    host_acc(1'b1, A_WIN + 8'd3, 2'd0, 32'hFFFF_FF77, rd, w);
    chk("R5 lane3 be", {28'b0, last_be}, 32'h8);
    chk("R5 lane3 data", last_wdata, 32'h7700_0000);
    host_acc(1'b1, A_WIN, 2'd0, 32'h1234_5601, rd, w);
    chk("R5 lane0 be", {28'b0, last_be}, 32'h1);
    host_acc(1'b0, A_WIN + 8'd1, 2'd0, 32'h0, rd, w);
    chk("R5 merged dword", rd, 32'h77EF_A501);
  endtask

  task automatic t_disabled();
    logic [31:0] rd; int w; int n0;
    host_acc(1'b1, A_SEL, 2'd2, sel_word(1'b0, 8'h12, 5'h07, 3'h3, 6'h05), rd, w);
    n0 = req_count;
    host_acc(1'b0, A_WIN, 2'd2, 32'h0, rd, w);
    chk("R7 read all ones", rd, 32'hFFFF_FFFF);
    chk("R7 read no stall", w, 32'd0);
    host_acc(1'b1, A_WIN, 2'd2, 32'h0BAD_0BAD, rd, w);
    repeat (4) @(negedge clk);
    chk("R7 no request", req_count - n0, 32'd0);
    host_acc(1'b1, A_SEL, 2'd2, sel_word(1'b1, 8'h12, 5'h07, 3'h3, 6'h05), rd, w);
    host_acc(1'b0, A_WIN, 2'd2, 32'h0, rd, w);
    chk("R7 dropped write left target", rd, 32'h77EF_A501);
  endtask

  task automatic t_stall();
    logic [31:0] rd; int w;
    tgt_stall = 3; tgt_lat = 2;
    host_acc(1'b0, A_WIN, 2'd2, 32'h0, rd, w);
    chk("R8 stalled read waits", w, 32'd9);
    chk("R8 stalled read data", rd, 32'h77EF_A501);
    host_acc(1'b1, A_WIN, 2'd2, 32'hCAFE_F00D, rd, w);
    chk("R8 stalled write waits", w, 32'd9);
    tgt_stall = 0; tgt_lat = 0;
    host_acc(1'b0, A_WIN, 2'd2, 32'h0, rd, w);
    chk("R8 write landed", rd, 32'hCAFE_F00D);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_selector();
    t_ctrl();
    t_iosize();
    t_unmapped();
    t_word();
    t_half();
    t_byte();
    t_disabled();
    t_stall();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule